// File: doc/BRIEF.md
# Phase-Locked Stepped Sine Drive Generator

This block drives an external resistor-ladder DAC with a 4-bit stepped sine. One period of the tone is sixteen codes played in circular order. Each code is held for a fixed number of clock cycles, set by a parameter. At a 40 MHz clock, 100 cycles per step gives a 400 kHz update rate and a 25 kHz tone.

A single counter paces both the code updates and the conversion strobe for the ADC. The strobe is therefore tied to the drive waveform by construction and cannot drift against it. While the block is disabled, a programmable starting index is loaded. It sets which table entry plays first when the block is enabled. Changing it moves the phase between the drive and the sampling in steps of 1/16 of a period, which lets the demodulator's phase error be tuned to zero. A one-cycle marker flags the strobe on which entry 0 is played, so downstream logic can align to the start of each period.

Top module: `sine_step_gen`

## Requirements
- R1: While reset is high, and after it with enable low, `dac_code` is 8 (mid-scale) and both `conv_stb` and `cyc_start` are 0.
- R2: The table is code(k) = floor(7.5 + 7.5·sin(2πk/16) + 0.5) for index k = 0..15. Written out, k = 0..15 gives 8, 10, 13, 14, 15, 14, 13, 10, 8, 5, 2, 1, 0, 1, 2, 5.
- R3: On the first rising edge with `en` high after a disabled period, `dac_code` takes code(`phase_ofs`), loaded while disabled. Strobe n of a run (counting from 0) carries code((`phase_ofs` + n) mod 16).
- R4: While `en` stays high, `conv_stb` is a one-cycle pulse. It occurs on the first enabled edge and then exactly every `TICK_CYC` cycles, with no strobe skipped or moved.
- R5: While enabled, `dac_code` changes only in cycles where `conv_stb` is 1, and it is updated in the same cycle as the strobe.
- R6: `cyc_start` is 1 exactly in the strobe cycles whose code comes from table index 0.
- R7: On the first edge with `en` low, `dac_code` returns to 8 and the strobes stop. The next enabled run starts again from the offset, with a full step length.
- R8: Changes on `phase_ofs` while `en` is high have no effect on the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the output at mid-scale and reloads the start index |
| phase_ofs | input | 4 | Start index loaded while disabled (phase between drive and sampling) |
| dac_code | output | 4 | Registered code for the resistor-ladder DAC |
| conv_stb | output | 1 | One-cycle ADC conversion strobe, aligned to each code update |
| cyc_start | output | 1 | One-cycle marker on the strobe that plays table entry 0 |

## Verification
The hardest cases to reach from the ports are the index wrap from 15 to 0, with its start-of-period marker, and a disable that lands partway through a step. The wrap only appears many steps into a run unless the start index is chosen for it. The stimulus therefore combines directed offsets of 15 and 0 with random offsets and random run lengths that are not multiples of the step length. Each run also toggles `phase_ofs` at random points while enabled, so that a change which leaked into the run would show up in the code sequence.

// File: rtl/sine_step_pkg.sv
package sine_step_pkg;

  localparam int CODE_W = 4;
  localparam int IDX_W  = 4;
  localparam int DEPTH  = 1 << IDX_W;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1 << (CODE_W - 1));

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // Offset sine rounded half-up; the upper half mirrors the lower half around mid-scale.
  function automatic code_t sine_code(input int k);
    code_t q;
    case (k % 8)
      0: q = 4'd8;
      1: q = 4'd10;
      2: q = 4'd13;
      3: q = 4'd14;
      4: q = 4'd15;
      5: q = 4'd14;
      6: q = 4'd13;
      default: q = 4'd10;
    endcase
    if ((k % 16) >= 8) begin
      case (k % 8)
        0: q = 4'd8;
        1: q = 4'd5;
        2: q = 4'd2;
        3: q = 4'd1;
        4: q = 4'd0;
        5: q = 4'd1;
        6: q = 4'd2;
        default: q = 4'd5;
      endcase
    end
    return q;
  endfunction

endpackage

// File: rtl/sine_step_timebase.sv
module sine_step_timebase #(
  parameter int TICK_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CNT_W = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;

  logic [CNT_W-1:0] cnt;

  // Shared pacing counter: restarts at zero whenever the run is disabled.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (int'(cnt) == TICK_CYC - 1) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == '0);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < TICK_CYC);

  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);

endmodule

// File: rtl/sine_step_index.sv
module sine_step_index
  import sine_step_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  idx_t phase_ofs,
  output idx_t idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (!en) begin
      idx <= phase_ofs;
    end else if (tick) begin
      idx <= idx + 1'b1;
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> idx == IDX_W'($past(idx) + 1'b1));

  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> idx == $past(phase_ofs));

  p_ofs_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(idx));

endmodule

// File: rtl/sine_step_rom.sv
module sine_step_rom
  import sine_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  rd,
  input  idx_t  addr,
  output code_t code
);

  code_t tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
    assign tbl[k] = sine_code(k);
  end

  // Registered read so the table maps onto a synchronous ROM.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      code <= MID_CODE;
    end else if (rd) begin
      code <= tbl[addr];
    end
  end

  p_mid_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> code == MID_CODE);

  p_read_r2: assert property (@(posedge clk) disable iff (rst)
    (en && rd && addr == '0) |=> code == MID_CODE);

endmodule

// File: rtl/sine_step_gen.sv
module sine_step_gen
  import sine_step_pkg::*;
#(
  parameter int TICK_CYC = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IDX_W-1:0] phase_ofs,
  output logic [CODE_W-1:0] dac_code,
  output logic             conv_stb,
  output logic             cyc_start
);
  localparam int GAP_W = $clog2(TICK_CYC + 1);

  logic tick;
  idx_t idx;

  sine_step_timebase #(.TICK_CYC(TICK_CYC)) u_tb (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .tick (tick)
  );

  sine_step_index u_idx (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tick      (tick),
    .phase_ofs (phase_ofs),
    .idx       (idx)
  );

  sine_step_rom u_rom (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .rd   (tick),
    .addr (idx),
    .code (dac_code)
  );

  // Strobes registered on the same edge as the code update.
  always_ff @(posedge clk) begin
    if (rst) begin
      conv_stb  <= 1'b0;
      cyc_start <= 1'b0;
    end else begin
      conv_stb  <= tick;
      cyc_start <= tick && (idx == '0);
    end
  end

  // Gap counter for the strobe spacing check.
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (conv_stb) begin
        gap_q <= '0;
      end else if (int'(gap_q) < TICK_CYC) begin
        gap_q <= gap_q + 1'b1;
      end
      if (!en) begin
        seen_q <= 1'b0;
      end else if (conv_stb) begin
        seen_q <= 1'b1;
      end
    end
  end

  p_no_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(en) && int'(gap_q) == TICK_CYC - 1) |-> conv_stb);

  p_no_early_r4: assert property (@(posedge clk) disable iff (rst)
    (conv_stb && seen_q) |-> int'(gap_q) == TICK_CYC - 1);

  p_stb_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    conv_stb |=> !conv_stb);

  p_marker_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> conv_stb);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(dac_code));

endmodule

// File: tb/sine_step_gen_bench.sv
module sine_step_gen_bench;

  localparam int N = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] phase_ofs = 4'd0;
  logic [3:0] dac_code;
  logic       conv_stb;
  logic       cyc_start;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sine_step_gen #(.TICK_CYC(N)) u_sine_step_gen (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .phase_ofs (phase_ofs),
    .dac_code  (dac_code),
    .conv_stb  (conv_stb),
    .cyc_start (cyc_start)
  );

  function automatic int exp_code(input int k);
    real v;
    v = 7.5 + 7.5 * $sin(2.0 * 3.14159265358979 * real'(k) / 16.0);
    return int'($floor(v + 0.5));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R7 idle code", int'(dac_code), 8);
      chk("R7 idle strobe", int'(conv_stb), 0);
      chk("R7 idle marker", int'(cyc_start), 0);
    end
  endtask

  // One enabled run of ncyc cycles starting from offset ofs.
  task automatic run(input int ofs, input int ncyc, input bit jitter_ofs);
    @(negedge clk);
    phase_ofs = 4'(ofs);
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      begin
        int step;
        int k;
        step = i / N;
        k    = (ofs + step) % 16;
        // R3 / R5: code follows the table from the offset, held between strobes (R2 values).
        chk("R3 code", int'(dac_code), exp_code(k));
        chk("R4 strobe", int'(conv_stb), (i % N == 0) ? 1 : 0);
        chk("R6 marker", int'(cyc_start), ((i % N == 0) && k == 0) ? 1 : 0);
      end
      // R8: offset changes while enabled must not disturb the run.
      if (jitter_ofs && ($urandom % 7 == 0)) phase_ofs = 4'($urandom);
    end
    en = 1'b0;
    check_idle(3);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset code", int'(dac_code), 8);
    chk("R1 reset strobe", int'(conv_stb), 0);
    chk("R1 reset marker", int'(cyc_start), 0);
    rst = 1'b0;
    check_idle(5);

    // R2: independent table check against the written-out values.
    chk("R2 table k4", exp_code(4), 15);
    chk("R2 table k12", exp_code(12), 0);

    run(0, 17 * N, 1'b0);
    run(15, 3 * N + 1, 1'b1);
    run(8, N / 2, 1'b1);
    run(3, 1, 1'b0);
    for (int r = 0; r < 8; r++) begin
      run(int'($urandom % 16), int'(1 + ($urandom % (20 * N))), 1'b1);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule